// File: doc/BRIEF.md
# Serial Bit-Rate Enable Generator

This block turns a system clock into two single-cycle enables for a serial port. One is a sampling strobe for the receiver at sixteen times the bit rate. The other is a bit strobe for the transmitter at the bit rate. Both come from two divider stages in series. The first stage divides the clock by 1, 3, 4 or 13. The second stage divides by a power of two from 1 to 128. A third counter then takes every sixteenth sampling strobe as the bit strobe.

An 8-bit configuration byte sets the rate, and it can be rewritten at any moment. Each write restarts every counter from zero, so the new rate is clean from the write onward. A test bit in the same byte holds all counters at zero for as long as it is set. A second test bit is only stored.

Top module: `sci_rate_gen`

## Requirements
- R1: After reset the configuration reads 0x00, and both `rx_sample_en` and `tx_bit_en` are low.
- R2: The configuration byte is laid out as follows. Bit 7 is the counter hold. Bit 6 always reads 0. Bits 5:4 select the prescaler. Bit 3 is a stored test bit. Bits 2:0 select the rate. Every bit except bit 6 reads back as written.
- R3: Prescaler select 00 divides the clock by 1, 01 by 3, 10 by 4 and 11 by 13.
- R4: A rate select value n (0 to 7) divides the prescaler output by a further 2^n.
- R5: With P = prescale ratio × 2^n, `rx_sample_en` is high for exactly 16 cycles in every 16·P cycles. It first goes high P clock edges after the edge that takes the write, and then every P cycles.
- R6: `tx_bit_en` pulses once every 16·P cycles. Its first pulse comes 16·P edges after the write edge, and it is only ever high together with `rx_sample_en`.
- R7: A write restarts all counters, and both enables are low in the cycle after the write edge.
- R8: While the counter-hold bit is 1, both enables stay low.
- R9: With the configuration at 0x00, `tx_bit_en` pulses every 16 clock cycles, which is a bit rate of the clock divided by 16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration byte |
| cfg_wdata | input | 8 | Configuration byte to write |
| cfg_rdata | output | 8 | Current configuration byte |
| rx_sample_en | output | 1 | One-cycle receive sampling enable at 16x the bit rate |
| tx_bit_en | output | 1 | One-cycle transmit bit enable |

## Verification
A wrong count in the prescaler or the power-of-two stage shows up on `rx_sample_en`. Its first pulse arrives at the wrong edge after a write, within P cycles. A fault in the sixteen-count stage or in the restart logic shifts the first `tx_bit_en` away from edge 16·P. Each configuration in the table is therefore timed from its own write edge, and both the first pulses and the number of high cycles are compared against P. The hold bit and the readback are checked directly at the ports.

// File: rtl/sci_rate_pkg.sv
package sci_rate_pkg;
  localparam int CFG_W   = 8;
  localparam int PSEL_W  = 2;
  localparam int RATE_W  = 3;
  localparam int PCNT_W  = 4;

  function automatic logic [PCNT_W-1:0] presc_ratio(input logic [PSEL_W-1:0] sel);
    case (sel)
      2'd0:    presc_ratio = 4'd1;
      2'd1:    presc_ratio = 4'd3;
      2'd2:    presc_ratio = 4'd4;
      default: presc_ratio = 4'd13;
    endcase
  endfunction
endpackage

// File: rtl/sci_cfg_reg.sv
module sci_cfg_reg
  import sci_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [CFG_W-1:0]  wdata,
  output logic [CFG_W-1:0]  rdata,
  output logic              hold,
  output logic [PSEL_W-1:0] psel,
  output logic [RATE_W-1:0] rate
);
  logic              hold_q, tbit_q;
  logic [PSEL_W-1:0] psel_q;
  logic [RATE_W-1:0] rate_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= 1'b0;
      tbit_q <= 1'b0;
      psel_q <= '0;
      rate_q <= '0;
    end else if (we) begin
      hold_q <= wdata[7];
      psel_q <= wdata[5:4];
      tbit_q <= wdata[3];
      rate_q <= wdata[2:0];
    end
  end

  assign rdata = {hold_q, 1'b0, psel_q, tbit_q, rate_q};
  assign hold  = hold_q;
  assign psel  = psel_q;
  assign rate  = rate_q;

  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (rst)
    we |=> (rdata == {$past(wdata[7]), 1'b0, $past(wdata[5:0])})); // R2
endmodule

// File: rtl/sci_prescaler.sv
module sci_prescaler
  import sci_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [PSEL_W-1:0] psel,
  output logic              tick
);
  logic [PCNT_W-1:0] cnt_q;
  logic [PCNT_W-1:0] lim;

  assign lim  = presc_ratio(psel) - 1'b1;
  assign tick = (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || clr)  cnt_q <= '0;
    else if (tick)   cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  AST_PRESC_RANGE: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> (cnt_q <= lim)); // R3
endmodule

// File: rtl/sci_pow2_div.sv
module sci_pow2_div #(
  parameter int SEL_W = 3,
  localparam int CNT_W = (1 << SEL_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             in_tick,
  input  logic [SEL_W-1:0] sel,
  output logic             out_tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] mask;

  always_comb begin
    mask = '0;
    for (int b = 0; b < CNT_W; b++)
      if (b < int'(sel)) mask[b] = 1'b1;
  end

  assign out_tick = in_tick && (cnt_q == mask);

  always_ff @(posedge clk) begin
    if (rst || clr)     cnt_q <= '0;
    else if (out_tick)  cnt_q <= '0;
    else if (in_tick)   cnt_q <= cnt_q + 1'b1;
  end

  AST_POW2_RANGE: assert property (@(posedge clk) disable iff (rst)
    !$past(clr) |-> ((cnt_q & ~mask) == '0)); // R4
endmodule

// File: rtl/sci_subdiv.sv
module sci_subdiv #(
  parameter int RATIO = 16,
  localparam int CNT_W = (RATIO > 1) ? $clog2(RATIO) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic in_tick,
  output logic out_tick
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RATIO - 1);
  logic [CNT_W-1:0] cnt_q;

  assign out_tick = in_tick && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr)     cnt_q <= '0;
    else if (out_tick)  cnt_q <= '0;
    else if (in_tick)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sci_rate_gen.sv
module sci_rate_gen
  import sci_rate_pkg::*;
#(
  parameter int OVERSAMPLE = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic [CFG_W-1:0] cfg_rdata,
  output logic             rx_sample_en,
  output logic             tx_bit_en
);
  logic              hold;
  logic [PSEL_W-1:0] psel;
  logic [RATE_W-1:0] rate;
  logic              clr, pre_tick, smp_tick, bit_tick;

  assign clr = cfg_we | hold;

  sci_cfg_reg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata),
    .rdata(cfg_rdata), .hold(hold), .psel(psel), .rate(rate)
  );

  sci_prescaler u_pre (
    .clk(clk), .rst(rst), .clr(clr), .psel(psel), .tick(pre_tick)
  );

  sci_pow2_div #(.SEL_W(RATE_W)) u_pow2 (
    .clk(clk), .rst(rst), .clr(clr), .in_tick(pre_tick),
    .sel(rate), .out_tick(smp_tick)
  );

  sci_subdiv #(.RATIO(OVERSAMPLE)) u_sub (
    .clk(clk), .rst(rst), .clr(clr), .in_tick(smp_tick), .out_tick(bit_tick)
  );

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      rx_sample_en <= 1'b0;
      tx_bit_en    <= 1'b0;
    end else begin
      rx_sample_en <= smp_tick;
      tx_bit_en    <= bit_tick;
    end
  end

  AST_TX_WITH_RX: assert property (@(posedge clk) disable iff (rst)
    tx_bit_en |-> rx_sample_en); // R6
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (rst)
    cfg_we |=> (!rx_sample_en && !tx_bit_en)); // R7
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    hold |=> (!rx_sample_en && !tx_bit_en)); // R8
  AST_RESET_LOW: assert property (@(posedge clk)
    rst |=> (!rx_sample_en && !tx_bit_en && cfg_rdata == '0)); // R1
endmodule

// File: tb/sci_rate_gen_tb.sv
`timescale 1ns/1ps
module sci_rate_gen_tb_top;
  logic       clk = 1'b0;
  logic       rst;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic [7:0] cfg_rdata;
  logic       rx_sample_en, tx_bit_en;

  int total = 0;
  int bad   = 0;

  always #2.5 clk = ~clk;

  sci_rate_gen dut_i (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .rx_sample_en(rx_sample_en), .tx_bit_en(tx_bit_en)
  );

  localparam int NV = 7;
  localparam logic [7:0] VCFG [NV] = '{8'h00, 8'h10, 8'h21, 8'h30, 8'h33, 8'h17, 8'h37};
  localparam int         VPER [NV] = '{1, 3, 8, 13, 104, 384, 1664};

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_vec(input logic [7:0] v, input int p);
    int first_rx, first_tx, rx_hi, tx_hi;
    write_cfg(v);
    check("R7 rx low after write", int'(rx_sample_en), 0);
    check("R7 tx low after write", int'(tx_bit_en), 0);
    first_rx = -1; first_tx = -1; rx_hi = 0; tx_hi = 0;
    for (int i = 1; i <= 16 * p; i++) begin
      @(negedge clk);
      if (rx_sample_en) begin rx_hi++; if (first_rx < 0) first_rx = i; end
      if (tx_bit_en)    begin tx_hi++; if (first_tx < 0) first_tx = i; end
    end
    check("R3 R4 R5 first rx edge", first_rx, p);
    check("R5 rx high cycles", rx_hi, 16);
    check("R6 first tx edge", first_tx, 16 * p);
    check("R6 tx pulses", tx_hi, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int n;
    rst = 1'b1; cfg_we = 1'b0; cfg_wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 cfg after reset", int'(cfg_rdata), 0);
    check("R1 rx after reset", int'(rx_sample_en), 0);
    check("R1 tx after reset", int'(tx_bit_en), 0);
    rst = 1'b0;

    for (int k = 0; k < NV; k++) run_vec(VCFG[k], VPER[k]);

    // R9: default config gives a bit strobe every 16 cycles
    write_cfg(8'h00);
    n = 0;
    for (int i = 1; i <= 48; i++) begin
      @(negedge clk);
      if (tx_bit_en && (i % 16 != 0)) n++;
      if (!tx_bit_en && (i % 16 == 0)) n++;
    end
    check("R9 tx every 16 cycles mismatches", n, 0);

    // R2: readback, bit 6 reads 0, test bit stored
    write_cfg(8'h4F);
    check("R2 readback 0x4F", int'(cfg_rdata), 8'h0F);
    write_cfg(8'h3A);
    check("R2 readback 0x3A", int'(cfg_rdata), 8'h3A);

    // R8: hold bit keeps enables low
    write_cfg(8'h80);
    check("R2 readback hold", int'(cfg_rdata), 8'h80);
    n = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (rx_sample_en || tx_bit_en) n++;
    end
    check("R8 pulses while held", n, 0);

    // R7: rewrite mid-count restarts cleanly
    write_cfg(8'h30);
    repeat (7) @(negedge clk);
    run_vec(8'h10, 3);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule